// File: doc/BRIEF.md
# Synchronous Character Hunt Detector

This block finds character alignment in a received synchronous bit stream that advances one bit per strobe. While hunting, each received bit is shifted into a window register. The window is compared with a sync pattern chosen by a two-bit mode input. There are four modes: a single programmed character, two programmed characters joined into one longer pattern, a fixed flag byte, and an active-low external sync pin.

When a match is found the detector declares sync. From the next bit onward it groups the stream into 8-bit characters and pulses a valid strobe for each completed character. In single-character mode it can drop received characters that equal the fill pattern. A hunt command sends the detector back to hunting at any time.

Top module: `sync_hunt_top`

## Requirements
- R1: After reset, `synced` and `char_valid` are 0. The external sync pin is treated as inactive (high) on the first strobe after reset, even if the pin was held low during reset.
- R2: In mode 2'b00 with `long_sel`=1, sync is declared on the strobe whose bit completes the 8 most recent bits equal to `pat_hunt`. The earliest of those bits is compared with bit 7.
- R3: In mode 2'b00 with `long_sel`=0, only the 6 most recent bits are compared, against `pat_hunt[5:0]`.
- R4: In mode 2'b01 with `long_sel`=1, the 16 most recent bits are compared with {`pat_hunt`, `pat_fill`}, with `pat_hunt` received first. Receiving `pat_hunt` alone does not sync.
- R5: In mode 2'b01 with `long_sel`=0, the 12 most recent bits are compared with {`pat_hunt[5:0]`, `pat_fill[5:0]`}.
- R6: In mode 2'b10, the window is compared with the fixed byte 8'h7E (01111110), and the pattern inputs have no effect.
- R7: In mode 2'b11, pattern matching plays no part. Sync is declared on a strobe when `ext_sync_n` was low on the previous clock edge.
- R8: A pattern match counts only once at least as many bits as the selected pattern length have been received since the last hunt entry.
- R9: After sync, every 8th strobe completes a character. `char_valid` is high for one clock after that strobe, and `char_data` holds the character with its first-received bit in bit 7. The bit that completed the sync is not part of any character.
- R10: In mode 2'b00 with `strip_en`=1, a completed character equal to `pat_fill` produces no `char_valid`. In other modes, stripping never happens.
- R11: `hunt_cmd` clears `synced` on the next edge and returns the detector to hunting. It also empties the window count, so a fresh full window is needed before the next match.
- R12: `char_valid` is never high while `synced` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Strobe: `rx_bit` is valid this cycle |
| rx_bit | input | 1 | Received serial data bit |
| mode | input | 2 | 00 single, 01 joined pair, 10 flag, 11 external pin |
| long_sel | input | 1 | 1: 8/16-bit pattern, 0: 6/12-bit pattern |
| pat_hunt | input | 8 | Receive sync character (first half in joined mode) |
| pat_fill | input | 8 | Fill character (second half in joined mode, strip compare) |
| strip_en | input | 1 | Drop characters equal to `pat_fill` in single mode |
| ext_sync_n | input | 1 | Active-low external sync request |
| hunt_cmd | input | 1 | Return to hunting |
| synced | output | 1 | Sync acquired |
| char_valid | output | 1 | One-clock strobe for a completed character |
| char_data | output | 8 | Last completed character |

## Verification
On every cycle, the assertions check the framing invariants:
- a character strobe appears only while synced and only after a bit strobe;
- the strobe is never high on two consecutive cycles;
- a hunt command clears sync;
- a stripped value never appears on the output;
- sync in external mode rises only after the pin was low.

Only the bench scenarios can show that each mode matches the right bits in the right order. The same applies to the short-window case, where stale bits left from before a hunt would otherwise complete a pattern. The exact sequence of delivered characters is compared against a scoreboard.

// File: rtl/sync_hunt_pkg.sv
// Shared definitions for the sync hunt detector: mode encoding and flag byte.
package sync_hunt_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_PAIR   = 2'b01,
        MODE_FLAG   = 2'b10,
        MODE_EXT    = 2'b11
    } hunt_mode_e;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;
endpackage

// File: rtl/sync_shift_reg.sv
// Window register for received bits plus a saturating count of bits received
// since the last hunt entry. Assumes shift_en pulses once per received bit.
module sync_shift_reg #(
    parameter int SR_W  = 16,
    parameter int CNT_W = $clog2(SR_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             clear,
    input  logic             din,
    output logic [SR_W-1:0]  sr_q,
    output logic [CNT_W-1:0] fill_q
);
    localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(SR_W);

    // Shift in new bits; count them up to the window size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            fill_q <= '0;
        end else if (clear) begin
            fill_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[SR_W-2:0], din};
            if (fill_q != FILL_MAX) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sync_pattern_match.sv
// Compares the bit window (including the bit arriving now) against the
// pattern selected by the mode and length inputs. Purely combinational.
// Assumes CHAR_W >= 8 so that the flag byte fits in one character.
module sync_pattern_match
    import sync_hunt_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int SR_W   = 2 * CHAR_W,
    parameter int CNT_W  = $clog2(SR_W + 1)
) (
    input  logic [SR_W-1:0]   win,
    input  logic [CNT_W-1:0]  fill_nx,
    input  hunt_mode_e        mode,
    input  logic              long_sel,
    input  logic [CHAR_W-1:0] pat_hunt,
    input  logic [CHAR_W-1:0] pat_fill,
    output logic              hit_pat
);
    localparam int SHORT_W = CHAR_W - 2;
    localparam logic [CNT_W-1:0] NEED_S1 = CNT_W'(SHORT_W);
    localparam logic [CNT_W-1:0] NEED_L1 = CNT_W'(CHAR_W);
    localparam logic [CNT_W-1:0] NEED_S2 = CNT_W'(2 * SHORT_W);
    localparam logic [CNT_W-1:0] NEED_L2 = CNT_W'(SR_W);

    logic             eq;
    logic [CNT_W-1:0] need;

    // Select the pattern and its length, then compare the window tail.
    always_comb begin
        eq   = 1'b0;
        need = '0;
        unique case (mode)
            MODE_SINGLE: begin
                if (long_sel) begin
                    need = NEED_L1;
                    eq   = (win[CHAR_W-1:0] == pat_hunt);
                end else begin
                    need = NEED_S1;
                    eq   = (win[SHORT_W-1:0] == pat_hunt[SHORT_W-1:0]);
                end
            end
            MODE_PAIR: begin
                if (long_sel) begin
                    need = NEED_L2;
                    eq   = (win == {pat_hunt, pat_fill});
                end else begin
                    need = NEED_S2;
                    eq   = (win[2*SHORT_W-1:0] ==
                            {pat_hunt[SHORT_W-1:0], pat_fill[SHORT_W-1:0]});
                end
            end
            MODE_FLAG: begin
                need = NEED_L1;
                eq   = (win[CHAR_W-1:0] == CHAR_W'(FLAG_BYTE));
            end
            default: begin
                need = '0;
                eq   = 1'b0;
            end
        endcase
        hit_pat = eq && (fill_nx >= need);
    end
endmodule

// File: rtl/sync_char_framer.sv
// Hunt/sync state and character framing. After a hit it counts strobes and
// emits a one-clock valid for each completed character unless dropped.
// Assumes hit and drop are evaluated on the same strobe as the current bit.
module sync_char_framer #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              hunt_cmd,
    input  logic              hit,
    input  logic              drop,
    input  logic [CHAR_W-1:0] char_in,
    output logic              synced,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data
);
    localparam int BIT_W = $clog2(CHAR_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAR_W - 1);

    logic [BIT_W-1:0] bit_cnt;

    // State update: enter sync on hit, then frame characters every CHAR_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced     <= 1'b0;
            bit_cnt    <= '0;
            char_valid <= 1'b0;
            char_data  <= '0;
        end else begin
            char_valid <= 1'b0;
            if (hunt_cmd) begin
                synced  <= 1'b0;
                bit_cnt <= '0;
            end else if (bit_en) begin
                if (!synced) begin
                    if (hit) begin
                        synced  <= 1'b1;
                        bit_cnt <= '0;
                    end
                end else if (bit_cnt == LAST_BIT) begin
                    bit_cnt    <= '0;
                    char_valid <= !drop;
                    char_data  <= char_in;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sync_hunt_top.sv
// Top of the sync hunt detector: registers the external sync pin, builds the
// window including the arriving bit, and combines the matcher with the framer.
// Assumes bit_en marks each 1x received bit; ext_sync_n is synchronous to clk.
module sync_hunt_top
    import sync_hunt_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic [1:0]        mode,
    input  logic              long_sel,
    input  logic [CHAR_W-1:0] pat_hunt,
    input  logic [CHAR_W-1:0] pat_fill,
    input  logic              strip_en,
    input  logic              ext_sync_n,
    input  logic              hunt_cmd,
    output logic              synced,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data
);
    localparam int SR_W  = 2 * CHAR_W;
    localparam int CNT_W = $clog2(SR_W + 1);
    localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(SR_W);

    hunt_mode_e       mode_e;
    logic             ext_q;
    logic [SR_W-1:0]  sr_q;
    logic [CNT_W-1:0] fill_q;
    logic [CNT_W-1:0] fill_nx;
    logic [SR_W-1:0]  win;
    logic             hit_pat;
    logic             hit;
    logic             drop;

    assign mode_e = hunt_mode_e'(mode);

    // External sync pin register; reset forces it inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b1;
        end else begin
            ext_q <= ext_sync_n;
        end
    end

    sync_shift_reg #(.SR_W(SR_W), .CNT_W(CNT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_en),
        .clear    (hunt_cmd),
        .din      (rx_bit),
        .sr_q     (sr_q),
        .fill_q   (fill_q)
    );

    // Window and count as they will be once the arriving bit is included.
    always_comb begin
        win     = {sr_q[SR_W-2:0], rx_bit};
        fill_nx = (fill_q == FILL_MAX) ? fill_q : fill_q + 1'b1;
    end

    sync_pattern_match #(.CHAR_W(CHAR_W), .SR_W(SR_W), .CNT_W(CNT_W)) u_match (
        .win      (win),
        .fill_nx  (fill_nx),
        .mode     (mode_e),
        .long_sel (long_sel),
        .pat_hunt (pat_hunt),
        .pat_fill (pat_fill),
        .hit_pat  (hit_pat)
    );

    // Sync source selection and the strip decision for the completed character.
    always_comb begin
        hit  = (mode_e == MODE_EXT) ? !ext_q : hit_pat;
        drop = strip_en && (mode_e == MODE_SINGLE) && (win[CHAR_W-1:0] == pat_fill);
    end

    sync_char_framer #(.CHAR_W(CHAR_W)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .hunt_cmd   (hunt_cmd),
        .hit        (hit),
        .drop       (drop),
        .char_in    (win[CHAR_W-1:0]),
        .synced     (synced),
        .char_valid (char_valid),
        .char_data  (char_data)
    );
endmodule

// File: rtl/sync_hunt_checker.sv
// Cycle invariants of the sync hunt detector, bound onto the top module.
module sync_hunt_checker #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic [1:0]        mode,
    input logic [CHAR_W-1:0] pat_fill,
    input logic              strip_en,
    input logic              ext_sync_n,
    input logic              hunt_cmd,
    input logic              synced,
    input logic              char_valid,
    input logic [CHAR_W-1:0] char_data
);
    // R12: a character strobe only while synced
    p_valid_in_sync_r12: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> synced);

    // R11: hunt command drops sync on the next edge
    p_hunt_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> (!synced && !char_valid));

    // R9: each character strobe follows a bit strobe
    p_valid_after_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> $past(bit_en));

    // R9: the strobe lasts a single clock
    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    // R8: sync is only declared on a bit strobe
    p_sync_on_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced) |-> $past(bit_en));

    // R10: a stripped value never reaches the output in single mode
    p_strip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && $past(mode) == 2'b00 && $past(strip_en))
            |-> (char_data != $past(pat_fill)));

    // R7: external-mode sync follows a low pin one edge earlier
    p_ext_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(synced) && $past(mode) == 2'b11) |-> ($past(ext_sync_n, 2) == 1'b0));
endmodule

bind sync_hunt_top sync_hunt_checker #(.CHAR_W(CHAR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .mode       (mode),
    .pat_fill   (pat_fill),
    .strip_en   (strip_en),
    .ext_sync_n (ext_sync_n),
    .hunt_cmd   (hunt_cmd),
    .synced     (synced),
    .char_valid (char_valid),
    .char_data  (char_data)
);

// File: tb/sync_hunt_top_test.sv
// Scoreboard bench: the driver queues expected characters, the monitor
// compares them with each char_valid strobe.
module sync_hunt_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic [1:0] mode = 2'b11;
    logic       long_sel = 1'b1;
    logic [7:0] pat_hunt = 8'h96;
    logic [7:0] pat_fill = 8'h3C;
    logic       strip_en = 1'b0;
    logic       ext_sync_n = 1'b0;
    logic       hunt_cmd = 1'b0;
    logic       synced;
    logic       char_valid;
    logic [7:0] char_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2.5 clk = ~clk;

    sync_hunt_top #(.CHAR_W(8)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .rx_bit     (rx_bit),
        .mode       (mode),
        .long_sel   (long_sel),
        .pat_hunt   (pat_hunt),
        .pat_fill   (pat_fill),
        .strip_en   (strip_en),
        .ext_sync_n (ext_sync_n),
        .hunt_cmd   (hunt_cmd),
        .synced     (synced),
        .char_valid (char_valid),
        .char_data  (char_data)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every strobe pops one expected character.
    always @(negedge clk) begin
        if (rst_n && char_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R12: actual unexpected char %h expected none", char_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                if (char_data !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", r, char_data, e);
                end
            end
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_data(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        req_q.push_back(req);
        send_bits({8'h00, v}, 8);
    endtask

    task automatic do_hunt();
        @(negedge clk);
        hunt_cmd = 1'b1;
        @(negedge clk);
        hunt_cmd = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset with external mode and pin low; first strobe must not sync
        bit_en = 1'b1;
        repeat (3) @(negedge clk);
        chk({7'd0, synced}, 8'd0, "R1");
        chk({7'd0, char_valid}, 8'd0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        ext_sync_n = 1'b1;
        chk({7'd0, synced}, 8'd0, "R1");

        // R2: single 8-bit pattern
        mode = 2'b00; long_sel = 1'b1; pat_hunt = 8'h96; pat_fill = 8'h3C;
        do_hunt();
        send_bits(16'h0000, 4);
        send_bits(16'h004B, 7);
        chk({7'd0, synced}, 8'd0, "R2");
        send_bit(1'b0);
        chk({7'd0, synced}, 8'd1, "R2");
        send_data(8'h5A, "R9");
        send_data(8'hC3, "R9");

        // R11 and R8: stale window bits must not complete a match after hunt
        send_bit(1'b1);
        do_hunt();
        chk({7'd0, synced}, 8'd0, "R11");
        send_bits(16'h0016, 7);
        chk({7'd0, synced}, 8'd0, "R8");
        send_bits(16'h0096, 8);
        chk({7'd0, synced}, 8'd1, "R11");
        send_data(8'h0F, "R9");

        // R3: single 6-bit pattern (low six bits of 0xE5 = 100101)
        pat_hunt = 8'hE5; long_sel = 1'b0;
        do_hunt();
        send_bits(16'h0000, 8);
        send_bits(16'h0012, 5);
        chk({7'd0, synced}, 8'd0, "R3");
        send_bit(1'b1);
        chk({7'd0, synced}, 8'd1, "R3");
        send_data(8'h81, "R9");

        // R4: joined 16-bit pattern, first half alone does not sync
        mode = 2'b01; long_sel = 1'b1; pat_hunt = 8'h96; pat_fill = 8'h3C;
        do_hunt();
        send_bits(16'h0000, 8);
        send_bits(16'h0096, 8);
        chk({7'd0, synced}, 8'd0, "R4");
        send_bits(16'h003C, 8);
        chk({7'd0, synced}, 8'd1, "R4");
        send_data(8'h11, "R9");

        // R5: joined 12-bit pattern 010110_111100
        long_sel = 1'b0;
        do_hunt();
        send_bits(16'h0000, 12);
        send_bits(16'h05BC >> 1, 11);
        chk({7'd0, synced}, 8'd0, "R5");
        send_bit(1'b0);
        chk({7'd0, synced}, 8'd1, "R5");
        send_data(8'hF0, "R9");

        // R6: flag mode ignores the programmed pattern
        mode = 2'b10; long_sel = 1'b1;
        do_hunt();
        send_bits(16'h0000, 8);
        send_bits(16'h0096, 8);
        chk({7'd0, synced}, 8'd0, "R6");
        send_bits(16'h007E, 8);
        chk({7'd0, synced}, 8'd1, "R6");
        send_data(8'h7E, "R9");

        // R7: external pin mode, patterns alone never sync
        mode = 2'b11;
        do_hunt();
        send_bits(16'h007E, 8);
        send_bits(16'h0096, 8);
        chk({7'd0, synced}, 8'd0, "R7");
        @(negedge clk);
        ext_sync_n = 1'b0;
        send_bit(1'b1);
        ext_sync_n = 1'b1;
        chk({7'd0, synced}, 8'd1, "R7");
        send_data(8'h3C, "R9");

        // R10: strip fill characters in single mode only
        mode = 2'b00; long_sel = 1'b1; pat_hunt = 8'h96; pat_fill = 8'hAA; strip_en = 1'b1;
        do_hunt();
        send_bits(16'h0000, 8);
        send_bits(16'h0096, 8);
        chk({7'd0, synced}, 8'd1, "R10");
        send_data(8'h12, "R10");
        send_bits(16'h00AA, 8);
        send_data(8'h34, "R10");

        mode = 2'b01; pat_fill = 8'h3C;
        do_hunt();
        send_bits(16'h0000, 8);
        send_bits(16'h963C, 16);
        chk({7'd0, synced}, 8'd1, "R4");
        pat_fill = 8'hAA;
        send_data(8'hAA, "R10");

        repeat (4) @(negedge clk);
        chk(8'(exp_q.size()), 8'd0, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule